// File: doc/BRIEF.md
# I2C Channel-Select Slave Controller

This block is an I2C slave that owns a single byte-wide control register. The low four bits of that register drive four channel-enable outputs. Any mix of channels may be on at once, including none or all four. A bus master addresses the slave, writes a selection byte, and the selection reaches the enable outputs when the master closes the transfer with STOP. A read returns one byte. Its upper half carries the live interrupt-status inputs, and its lower half carries the enables currently in force.

SCL and SDA are asynchronous to the system clock. Each line passes through a two-flop synchroniser and a glitch filter. The filter only accepts a new level once the line has held it for `GLITCH_CYC` system clocks. Edge detection works on the filtered samples. The slave never drives SDA high. It asserts `sda_pull_o`, and the pad logic turns that into an open-drain low.

The protocol engine is a state machine with these states:
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: pulling SDA low to acknowledge the address.
- `ST_WR_BYTE`: shifting in a written byte.
- `ST_WR_ACK`: acknowledging a written byte.
- `ST_RD_BYTE`: driving the read byte out, MSB first.
- `ST_RD_ACK`: sampling the master's ACK or NACK.
- `ST_SKIP`: ignoring the bus.

Its transitions are:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on the SCL fall after the eighth bit if the address matches, otherwise to `ST_SKIP`.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` or `ST_RD_BYTE` on the next SCL fall, according to the R/W bit.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits.
- `ST_WR_ACK` returns to `ST_WR_BYTE` on the next SCL fall.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` returns to `ST_RD_BYTE` if the master acknowledged, otherwise goes to `ST_SKIP`.

Top module: `i2c_chansel_slave`

## Requirements
- R1: The slave answers the 7-bit address 1,1,1,0,0,A1,A0 (MSB first), with A1 = `addr_strap_i[1]` and A0 = `addr_strap_i[0]`. The eighth bit selects read (1) or write (0). On a match, `sda_pull_o` is held high for the whole high phase of the ninth SCL pulse.
- R2: On an address mismatch the slave leaves SDA released and ignores all further bits until the next START or STOP. Its enable outputs are unchanged by that transfer.
- R3: In write mode every received byte is acknowledged as in R1. Bit n (n = 0..3) of the byte enables channel n on `chan_en_o[n]`. Bits 7:4 of a written byte have no effect.
- R4: A written selection is held pending and appears on `chan_en_o` only after the following STOP, not at the end of the byte.
- R5: When several bytes are written in one transfer, only the last byte takes effect at STOP.
- R6: A read returns `{irq_stat_i[3:0], chan_en_o[3:0]}`, MSB first, driven while SCL is low. The slave releases SDA in the ninth bit slot. After a master NACK the slave drives nothing further.
- R7: A repeated START drops a partly received byte and any pending selection. A later STOP does not commit the dropped selection.
- R8: While `rst_n` is low, the enables are zero, SDA is released and the bus state machine returns to idle. This takes effect asynchronously.
- R9: A pulse on SCL or SDA shorter than `GLITCH_CYC` system clocks (3 by default) is not seen by the protocol logic.
- R10: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. After a STOP the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| addr_strap_i | input | 2 | Low two address bits from board straps |
| irq_stat_i | input | 4 | Interrupt status per channel, 1 = pending |
| chan_en_o | output | 4 | Channel enables, bit n = channel n |

## Verification
A wrong internal state shows up at the ports within one SCL pulse in most cases. A miscounted bit shifts the ACK slot, so `sda_pull_o` is sampled high or low in the wrong half-period. A bad address compare acknowledges a foreign address or fails its own. A pending selection that leaks early or is lost is only visible at `chan_en_o` around STOP or repeated START. For that reason the enables are sampled both before and after each closing condition. Filter faults appear as corrupted bytes after an injected short pulse.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

    localparam int CHAN_N = 4;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/chansel_line_filter.sv
module chansel_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [CW-1:0]          cnt_q;
    logic                   clean_q;

    assign synced  = sync_q[SYNC_STAGES-1];
    assign clean_o = clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_q <= 1'b1;
        end else if (synced == clean_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(HOLD_CYC - 1)) begin
            clean_q <= synced;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (HOLD_CYC >= 2) begin : g_hold_check
            // R9: a level change needs at least two prior differing samples
            p_glitch_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (clean_q != $past(clean_q)) |->
                    (($past(synced) != $past(clean_q)) &&
                     ($past(synced, 2) != $past(clean_q, 2))));
        end
    endgenerate

endmodule

// File: rtl/chansel_bus_events.sv
module chansel_bus_events
    import chansel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_c,
    input  logic     sda_c,
    output bus_evt_t evt_o
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_c;
            sda_prev_q <= sda_c;
        end
    end

    always_comb begin
        evt_o.start    = scl_c & scl_prev_q & sda_prev_q & ~sda_c;
        evt_o.stop     = scl_c & scl_prev_q & ~sda_prev_q & sda_c;
        evt_o.scl_rise = scl_c & ~scl_prev_q;
        evt_o.scl_fall = ~scl_c & scl_prev_q;
        evt_o.scl      = scl_c;
        evt_o.sda      = sda_c;
    end

endmodule

// File: rtl/chansel_ctrl.sv
module chansel_ctrl
    import chansel_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'b1110000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [1:0]        strap_i,
    input  logic [CHAN_N-1:0] irq_i,
    output logic [CHAN_N-1:0] chan_en_o,
    output logic              sda_pull_o
);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    bus_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic              rw_q;
    logic              mack_q;
    logic [CHAN_N-1:0] pend_q;
    logic              pend_vld_q;
    logic [CHAN_N-1:0] en_q;
    logic              addr_hit;

    assign addr_hit  = (rx_q[7:1] == (ADDR_BASE | {5'b0, strap_i}));
    assign chan_en_o = en_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (evt.start) begin
            state_d = ST_ADDR;
        end else if (evt.stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_ADDR:
                    if (evt.scl_fall && cnt_q == LAST_RX)
                        state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:
                    if (evt.scl_fall)
                        state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:
                    if (evt.scl_fall && cnt_q == LAST_RX) state_d = ST_WR_ACK;
                ST_WR_ACK:
                    if (evt.scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:
                    if (evt.scl_fall && cnt_q == LAST_TX) state_d = ST_RD_ACK;
                ST_RD_ACK:
                    if (evt.scl_fall) state_d = mack_q ? ST_RD_BYTE : ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            en_q       <= '0;
        end else if (evt.start) begin
            cnt_q      <= '0;
            pend_vld_q <= 1'b0;
        end else if (evt.stop) begin
            cnt_q      <= '0;
            pend_vld_q <= 1'b0;
            if (pend_vld_q) en_q <= pend_q;
        end else begin
            case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (evt.scl_rise) begin
                        rx_q  <= {rx_q[BYTE_W-2:0], evt.sda};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (evt.scl_fall && cnt_q == LAST_RX) begin
                        cnt_q <= '0;
                        if (state_q == ST_ADDR) begin
                            rw_q <= rx_q[0];
                        end else begin
                            pend_q     <= rx_q[CHAN_N-1:0];
                            pend_vld_q <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall && rw_q) begin
                        tx_q  <= {irq_i, en_q};
                        cnt_q <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (evt.scl_fall) begin
                        if (cnt_q == LAST_TX) begin
                            cnt_q <= '0;
                        end else begin
                            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise) begin
                        mack_q <= ~evt.sda;
                    end else if (evt.scl_fall && mack_q) begin
                        tx_q  <= {irq_i, en_q};
                        cnt_q <= '0;
                    end
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull_o = 1'b1;
            ST_RD_BYTE:             sda_pull_o = ~tx_q[BYTE_W-1];
            default:                sda_pull_o = 1'b0;
        endcase
    end

    // R4: enables move only in the cycle after a STOP was seen
    p_en_only_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != $past(en_q)) |-> $past(evt.stop));

    // R10: STOP returns the engine to idle
    p_idle_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.stop && !evt.start) |=> (state_q == ST_IDLE));

    // R7: repeated START leaves nothing pending
    p_rstart_drops_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> !pend_vld_q);

    // R1: slave never changes SDA while SCL stays high
    p_pull_steady_scl_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.scl && $past(evt.scl)) |-> $stable(sda_pull_o));

    // R2: ignoring state keeps SDA released
    p_skip_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !sda_pull_o);

    // R8: reset clears outputs
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r8: assert (en_q == '0 && !sda_pull_o && state_q == ST_IDLE);
        end
    end

endmodule

// File: rtl/i2c_chansel_slave.sv
module i2c_chansel_slave
    import chansel_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         GLITCH_CYC  = 3,
    parameter logic [6:0] ADDR_BASE   = 7'b1110000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull_o,
    input  logic [1:0]  addr_strap_i,
    input  logic [3:0]  irq_stat_i,
    output logic [3:0]  chan_en_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    bus_evt_t         evt;

    assign raw_lines = {scl_i, sda_i};

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            chansel_line_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .HOLD_CYC   (GLITCH_CYC)
            ) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (raw_lines[i]),
                .clean_o(clean_lines[i])
            );
        end
    endgenerate

    chansel_bus_events u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_c(clean_lines[1]),
        .sda_c(clean_lines[0]),
        .evt_o(evt)
    );

    chansel_ctrl #(
        .ADDR_BASE(ADDR_BASE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .strap_i   (addr_strap_i),
        .irq_i     (irq_stat_i),
        .chan_en_o (chan_en_o),
        .sda_pull_o(sda_pull_o)
    );

endmodule

// File: tb/i2c_chansel_slave_test.sv
module i2c_chansel_slave_test;

    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       sda_line;
    logic [1:0] strap = 2'b10;
    logic [3:0] irq = 4'h0;
    logic [3:0] chan_en;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_chansel_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .addr_strap_i(strap),
        .irq_stat_i  (irq),
        .chan_en_o   (chan_en)
    );

    typedef struct {
        string tag;
        int    val;
    } exp_t;

    exp_t exp_q[$];
    int   act_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int expv, input int actv);
        exp_t e;
        e.tag = tag;
        e.val = expv;
        exp_q.push_back(e);
        act_q.push_back(actv);
    endtask

    // monitor: pops and compares
    initial begin
        exp_t e;
        int   a;
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a != e.val) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", e.tag, a, e.val);
                end
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b0; wait_c(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b1; wait_c(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_c(Q);
        scl_m = 1'b1; wait_c(Q);
        sda_m = 1'b0; wait_c(Q);
        scl_m = 1'b0; wait_c(Q);
    endtask

    // glitch: 1 = short SCL pulse in low phase, 2 = short SDA dip in high phase
    task automatic send_bit(input bit b, input int glitch, output bit got);
        sda_m = b;
        wait_c(Q / 2);
        if (glitch == 1) begin
            scl_m = 1'b1; wait_c(1); scl_m = 1'b0;
        end
        wait_c(Q / 2);
        scl_m = 1'b1;
        wait_c(Q / 2);
        if (glitch == 2) begin
            sda_m = ~b; wait_c(2); sda_m = b;
        end
        got = sda_line;
        wait_c(Q / 2);
        scl_m = 1'b0;
        wait_c(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, input int gbit, input int gkind,
                              output bit acked);
        bit g;
        for (int i = 7; i >= 0; i--) send_bit(v[i], (i == gbit) ? gkind : 0, g);
        send_bit(1'b1, 0, g);
        acked = !g;
    endtask

    task automatic read_byte(input bit nack, output logic [7:0] v);
        bit g;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, 0, g);
            v[i] = g;
        end
        send_bit(nack, 0, g);
    endtask

    localparam logic [7:0] A_WR  = 8'hE4;
    localparam logic [7:0] A_RD  = 8'hE5;
    localparam logic [7:0] A_BAD = 8'hE0;

    initial begin
        bit         ack;
        bit         g;
        logic [7:0] rd;

        #1 rst_n = 1'b0;
        wait_c(5);
        rst_n = 1'b1;
        wait_c(8);
        check("R8 enables after reset", 0, chan_en);
        check("R8 sda released after reset", 0, sda_pull);

        // basic write, committed at STOP
        bus_start();
        write_byte(A_WR, -1, 0, ack);
        check("R1 address ack", 1, ack);
        write_byte(8'h05, -1, 0, ack);
        check("R3 data ack", 1, ack);
        check("R4 enables held before STOP", 0, chan_en);
        bus_stop();
        check("R4 R10 enables after STOP", 5, chan_en);

        // read with interrupt status
        irq = 4'b1010;
        bus_start();
        write_byte(A_RD, -1, 0, ack);
        check("R1 read address ack", 1, ack);
        read_byte(1'b1, rd);
        check("R6 read byte", 8'hA5, rd);
        check("R6 sda released after NACK", 0, sda_pull);
        bus_stop();
        check("R6 enables unchanged by read", 5, chan_en);

        // multiple bytes: last kept
        irq = 4'h0;
        bus_start();
        write_byte(A_WR, -1, 0, ack);
        write_byte(8'h03, -1, 0, ack);
        write_byte(8'h0C, -1, 0, ack);
        check("R5 second byte ack", 1, ack);
        bus_stop();
        check("R5 last byte kept", 4'hC, chan_en);

        // upper nibble of written byte ignored
        bus_start();
        write_byte(A_WR, -1, 0, ack);
        write_byte(8'hF9, -1, 0, ack);
        bus_stop();
        check("R3 upper bits ignored", 4'h9, chan_en);
        bus_start();
        write_byte(A_RD, -1, 0, ack);
        read_byte(1'b1, rd);
        bus_stop();
        check("R3 readback of written nibble", 8'h09, rd);

        // address mismatch
        bus_start();
        write_byte(A_BAD, -1, 0, ack);
        check("R2 no ack on foreign address", 0, ack);
        write_byte(8'h0F, -1, 0, ack);
        check("R2 no ack on ignored data", 0, ack);
        bus_stop();
        check("R2 enables unchanged", 4'h9, chan_en);

        // repeated START drops pending selection
        bus_start();
        write_byte(A_WR, -1, 0, ack);
        write_byte(8'h0F, -1, 0, ack);
        bus_rstart();
        write_byte(A_RD, -1, 0, ack);
        check("R7 ack after repeated START", 1, ack);
        read_byte(1'b1, rd);
        check("R7 read sees old enables", 8'h09, rd);
        bus_stop();
        check("R7 pending not committed", 4'h9, chan_en);

        // repeated START drops partial byte
        bus_start();
        write_byte(A_WR, -1, 0, ack);
        send_bit(1'b1, 0, g);
        send_bit(1'b0, 0, g);
        send_bit(1'b1, 0, g);
        bus_rstart();
        write_byte(A_WR, -1, 0, ack);
        write_byte(8'h06, -1, 0, ack);
        bus_stop();
        check("R7 partial byte abandoned", 4'h6, chan_en);

        // short pulses rejected
        bus_start();
        write_byte(A_WR, 2, 1, ack);
        check("R9 address ack with SCL glitch", 1, ack);
        write_byte(8'h0A, 3, 2, ack);
        check("R9 data ack with SDA glitch", 1, ack);
        bus_stop();
        check("R9 byte intact after glitches", 4'hA, chan_en);

        // all channels, then reset mid-transfer
        bus_start();
        write_byte(A_WR, -1, 0, ack);
        write_byte(8'h0F, -1, 0, ack);
        bus_stop();
        check("R3 all channels on", 4'hF, chan_en);
        bus_start();
        write_byte(A_WR, -1, 0, ack);
        write_byte(8'h03, -1, 0, ack);
        rst_n = 1'b0;
        wait_c(3);
        check("R8 enables cleared in reset", 0, chan_en);
        rst_n = 1'b1;
        wait_c(8);
        check("R8 sda released after reset", 0, sda_pull);
        bus_stop();
        check("R8 pending lost on reset", 0, chan_en);

        wait_c(10);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule